// File: doc/BRIEF.md
# Double-Data-Rate Write Burst Capture

This block is the receive side of a memory device's write path. A decoded write command arms it. It then samples the data bus and the per-byte mask lines on both edges of the incoming data strobe. It joins each rising-edge beat with the falling-edge beat that follows into one double-width word. Each word goes to the array-write interface with its mask bits and its pair-granular column address. The strobe is launched by the controller. Its first rising edge lands between 0.75 and 1.25 core clock periods after the command clock edge. The low preamble before that edge and the low postamble after the last beat never produce data.

Burst length is chosen per command as 2, 4 or 8 beats. A later write may continue the strobe stream, either after the whole earlier burst or part way through it, which shortens the earlier burst. A cut command, such as a read or precharge decoded elsewhere, may also shorten the newest burst. Captured pairs pass to the core clock through a two-entry buffer. The core clock drains that buffer one entry per cycle.

Top module: `ddr_wr_capture`

## Requirements
- R1: While reset is asserted and on the first clock after release, `aw_valid` is low.
- R2: The first beat of a burst is the data present at the first rising strobe edge after the write command. This holds for any launch delay from 0.75 to 1.25 clock periods. The low strobe before that edge yields nothing.
- R3: Beats alternate rising and falling edges. Each rising/falling pair produces exactly one `aw_valid` cycle. In that word, `aw_data[DW-1:0]` is the rising beat and `aw_data[2*DW-1:DW]` is the falling beat. Words leave in capture order.
- R4: `wr_bl` selects the burst: 0 gives 2 beats, 1 gives 4 beats, 2 or 3 gives 8 beats. The burst yields half that many pairs.
- R5: `wr_col` and `aw_col` count pairs. Successive pairs of one burst keep the column bits above the low log2(pairs) bits and increment those low bits modulo the pair count.
- R6: `dm` is sampled on the same edge as its beat. `aw_mask[MW-1:0]` carries the rising beat's lanes and `aw_mask[2*MW-1:MW]` the falling beat's lanes. Bit i covers byte i of its beat, and a 1 means the byte is not written.
- R7: Strobe edges outside a commanded burst are ignored. This covers edges before any write and edges after the last burst has ended. No `aw_valid` appears 8 or more cycles after the latest write command.
- R8: A write issued exactly as many cycles after the previous one as the previous burst has pairs continues the stream with no gap. Its first beat is the beat right after the previous burst's last beat.
- R9: A write issued x cycles after the previous write, with x smaller than the previous burst's pair count, cuts the previous burst to x pairs. The new burst's first beat directly follows those pairs.
- R10: `cut_cmd` asserted x cycles after the latest write cuts that burst to at most x pairs. Beats after that point are ignored. No `aw_valid` appears 3 or more cycles after the cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | Decoded write command, one cycle |
| wr_col | input | CW | Start column in pair units |
| wr_bl | input | 2 | Burst length select |
| cut_cmd | input | 1 | Decoded non-write command that ends the newest burst |
| dqs | input | 1 | Data strobe from the controller |
| dq | input | DW | Write data bus |
| dm | input | MW | Per-byte mask, 1 = do not write |
| aw_valid | output | 1 | Array write strobe, one cycle per pair |
| aw_col | output | CW | Pair column of the array write |
| aw_data | output | 2*DW | Falling beat over rising beat |
| aw_mask | output | 2*MW | Byte masks for the two beats |

## Verification
Single bursts of each length are launched at strobe delays of 0.75, 1.0 and 1.25 clock periods. These runs separate a correct first-beat choice from an off-by-one-edge capture, and they expose a wrong rising/falling half order. Start columns are chosen so that the pair addresses wrap inside the aligned block. Chained writes at the full spacing are set against writes issued early, which must shorten the earlier burst. A cut command is tested with the strobe still toggling after the cut. Extra strobe edges after a burst and edges with no command at all must yield no write. Every beat carries distinct data and mask values, so a swapped or dropped beat appears as a mismatch.

// File: rtl/ddr_wr_capture.sv
`timescale 1ns/1ps
module ddr_wr_capture #(
  parameter int DW = 16,
  parameter int CW = 9,
  localparam int MW = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cmd,
  input  logic [CW-1:0]   wr_col,
  input  logic [1:0]      wr_bl,
  input  logic            cut_cmd,
  input  logic            dqs,
  input  logic [DW-1:0]   dq,
  input  logic [MW-1:0]   dm,
  output logic            aw_valid,
  output logic [CW-1:0]   aw_col,
  output logic [2*DW-1:0] aw_data,
  output logic [2*MW-1:0] aw_mask
);

  // command slots, written in the core domain, consumed by the strobe domain
  logic [CW-1:0] c_col [2];
  logic [2:0]    c_np  [2];
  logic [2:0]    c_len [2];
  logic [1:0]    c_wp, rp;
  logic [2:0]    since;
  logic          last_ok;
  logic [2:0]    np_new;
  logic          li, ri;

  assign li     = ~c_wp[0];
  assign ri     = rp[0];
  assign np_new = (wr_bl == 2'd0) ? 3'd1 : (wr_bl == 2'd1) ? 3'd2 : 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wp    <= '0;
      since   <= 3'd7;
      last_ok <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        c_col[i] <= '0;
        c_np[i]  <= 3'd1;
        c_len[i] <= 3'd1;
      end
    end else begin
      if (since != 3'd7) since <= since + 3'd1;
      if (wr_cmd) begin
        c_col[c_wp[0]] <= wr_col;
        c_np[c_wp[0]]  <= np_new;
        c_len[c_wp[0]] <= np_new;
        c_wp    <= c_wp + 2'd1;
        since   <= 3'd1;
        last_ok <= 1'b1;
        if (last_ok && since < c_len[li]) c_len[li] <= since;
      end else if (cut_cmd && last_ok) begin
        if (since < c_len[li]) c_len[li] <= since;
        last_ok <= 1'b0;
      end
    end
  end

  // strobe domain: rising half
  logic          armed, rise_ok;
  logic [DW-1:0] r_dq;
  logic [MW-1:0] r_dm;

  assign armed = (c_wp != rp);

  always_ff @(posedge dqs or negedge rst_n) begin
    if (!rst_n) begin
      rise_ok <= 1'b0;
      r_dq    <= '0;
      r_dm    <= '0;
    end else begin
      rise_ok <= armed;
      if (armed) begin
        r_dq <= dq;
        r_dm <= dm;
      end
    end
  end

  // strobe domain: falling half, pairing and buffer write
  logic [1:0]      pidx, b_wp, b_rp;
  logic [2*DW-1:0] b_data [2];
  logic [2*MW-1:0] b_mask [2];
  logic [CW-1:0]   b_col  [2];
  logic [CW-1:0]   wm, pc, col_now;

  assign wm      = CW'(c_np[ri] - 3'd1);
  assign pc      = c_col[ri];
  assign col_now = (pc & ~wm) | ((pc + CW'(pidx)) & wm);

  always_ff @(negedge dqs or negedge rst_n) begin
    if (!rst_n) begin
      pidx <= '0;
      rp   <= '0;
      b_wp <= '0;
      for (int i = 0; i < 2; i++) begin
        b_data[i] <= '0;
        b_mask[i] <= '0;
        b_col[i]  <= '0;
      end
    end else if (rise_ok) begin
      b_data[b_wp[0]] <= {dq, r_dq};
      b_mask[b_wp[0]] <= {dm, r_dm};
      b_col[b_wp[0]]  <= col_now;
      b_wp <= b_wp + 2'd1;
      if ({1'b0, pidx} + 3'd1 >= c_len[ri]) begin
        pidx <= '0;
        rp   <= rp + 2'd1;
      end else begin
        pidx <= pidx + 2'd1;
      end
    end
  end

  // core domain drain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_rp     <= '0;
      aw_valid <= 1'b0;
      aw_col   <= '0;
      aw_data  <= '0;
      aw_mask  <= '0;
    end else begin
      aw_valid <= 1'b0;
      if (b_wp != b_rp) begin
        aw_valid <= 1'b1;
        aw_col   <= b_col[b_rp[0]];
        aw_data  <= b_data[b_rp[0]];
        aw_mask  <= b_mask[b_rp[0]];
        b_rp     <= b_rp + 2'd1;
      end
    end
  end

endmodule

// File: rtl/ddr_wr_capture_chk.sv
`timescale 1ns/1ps
module ddr_wr_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_cmd,
  input logic cut_cmd,
  input logic aw_valid
);
  logic [3:0] w_cnt, c_cnt;
  logic       c_act, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_cnt <= 4'd15;
      c_cnt <= 4'd15;
      c_act <= 1'b0;
      seen  <= 1'b0;
    end else begin
      if (w_cnt != 4'd15) w_cnt <= w_cnt + 4'd1;
      if (c_cnt != 4'd15) c_cnt <= c_cnt + 4'd1;
      if (wr_cmd) begin
        w_cnt <= 4'd1;
        c_act <= 1'b0;
        seen  <= 1'b1;
      end else if (cut_cmd) begin
        c_cnt <= 4'd1;
        c_act <= 1'b1;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !aw_valid);
  a_r7_no_write_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !aw_valid);
  a_r7_quiet_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cnt >= 4'd8) |-> !aw_valid);
  a_r10_quiet_after_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && c_cnt >= 4'd3) |-> !aw_valid);
endmodule

bind ddr_wr_capture ddr_wr_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .cut_cmd(cut_cmd), .aw_valid(aw_valid)
);

// File: tb/ddr_wr_capture_tb.sv
`timescale 1ns/1ps
module ddr_wr_capture_tb;
  localparam int DW = 16, CW = 9, MW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_cmd = 1'b0, cut_cmd = 1'b0, dqs = 1'b0;
  logic [CW-1:0] wr_col = '0;
  logic [1:0] wr_bl = '0;
  logic [DW-1:0] dq = '0;
  logic [MW-1:0] dm = '0;
  logic aw_valid;
  logic [CW-1:0] aw_col;
  logic [2*DW-1:0] aw_data;
  logic [2*MW-1:0] aw_mask;

  ddr_wr_capture #(.DW(DW), .CW(CW)) u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, n_seen = 0;
  string cur_req = "R1";
  int q_col[$];
  logic [2*DW-1:0] q_dat[$];
  logic [2*MW-1:0] q_msk[$];
  bit started = 0;

  function automatic logic [DW-1:0] bd(int s, int b);
    return DW'(s * 131 + b * 29 + 7);
  endfunction
  function automatic logic [MW-1:0] bm(int s, int b);
    return MW'((s + b * 3) % 4);
  endfunction

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && aw_valid) begin
      n_seen++;
      checks++;
      if (q_col.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected write col=%0d data=%h mask=%b exp none", cur_req, aw_col, aw_data, aw_mask);
      end else begin
        int ec; logic [2*DW-1:0] ed; logic [2*MW-1:0] em;
        ec = q_col.pop_front(); ed = q_dat.pop_front(); em = q_msk.pop_front();
        if (aw_col != CW'(ec) || aw_data != ed || aw_mask != em) begin
          fails++;
          $display("FAIL %s got col=%0d data=%h mask=%b exp col=%0d data=%h mask=%b",
                   cur_req, aw_col, aw_data, aw_mask, ec, ed, em);
        end
      end
    end
  end

  task automatic issue(int col, int bl);
    @(negedge clk); wr_cmd = 1; wr_col = CW'(col); wr_bl = 2'(bl);
    @(posedge clk); started = 1; #1 wr_cmd = 0;
  endtask

  task automatic run_case(string req, real ph, int n, int g[3], int cl[3], int bl[3],
                          int cut, int extra, int s);
    int p[3], l[3], b, nreal;
    cur_req = req;
    for (int i = 0; i < n; i++) p[i] = (bl[i] == 0) ? 1 : (bl[i] == 1) ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      int lim;
      lim = (i < n - 1) ? g[i+1] : (cut > 0 ? cut : p[i]);
      l[i] = (lim < p[i]) ? lim : p[i];
    end
    b = 0;
    for (int i = 0; i < n; i++) begin
      int pcol, m;
      pcol = cl[i]; m = p[i] - 1;
      for (int k = 0; k < l[i]; k++) begin
        q_col.push_back(((pcol & ~m) | ((pcol + k) & m)) % (1 << CW));
        q_dat.push_back({bd(s, b + 1), bd(s, b)});
        q_msk.push_back({bm(s, b + 1), bm(s, b)});
        b += 2;
      end
    end
    nreal = b;
    fork
      begin
        issue(cl[0], bl[0]);
        for (int i = 1; i < n; i++) begin
          repeat (g[i] - 1) @(posedge clk);
          issue(cl[i], bl[i]);
        end
        if (cut > 0) begin
          repeat (cut - 1) @(posedge clk);
          @(negedge clk); cut_cmd = 1;
          @(posedge clk); #1 cut_cmd = 0;
        end
      end
      begin
        wait (started);
        #(ph - 1.0);
        for (int k = 0; k < nreal + extra; k++) begin
          if (k < nreal) begin dq = bd(s, k); dm = bm(s, k); end
          else begin dq = DW'(16'hDEAD + k); dm = '1; end
          #1.0 dqs = (k % 2 == 0);
          #1.5;
        end
      end
    join
    repeat (10) @(posedge clk);
    started = 0;
    checks++;
    if (q_col.size() != 0) begin
      fails++;
      $display("FAIL %s missing writes: %0d left exp 0", req, q_col.size());
      q_col.delete(); q_dat.delete(); q_msk.delete();
    end
  endtask

  task automatic stray(int edges);
    int n0;
    cur_req = "R7";
    n0 = n_seen;
    for (int k = 0; k < edges; k++) begin
      dq = DW'(k * 77); dm = '0;
      #1.0 dqs = (k % 2 == 0);
      #1.5;
    end
    repeat (10) @(posedge clk);
    checks++;
    if (n_seen != n0) begin
      fails++;
      $display("FAIL R7 stray strobe writes got %0d exp 0", n_seen - n0);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (aw_valid !== 1'b0) begin fails++; $display("FAIL R1 aw_valid=%b exp 0", aw_valid); end
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    checks++;
    if (aw_valid !== 1'b0) begin fails++; $display("FAIL R1 after release aw_valid=%b exp 0", aw_valid); end

    stray(6);                                                                         // R7 before any write
    run_case("R2 R3 R5 nominal BL4",      5.0,  1, '{0,0,0}, '{3,0,0},   '{1,0,0}, 0, 0, 1);
    run_case("R2 R4 R5 early BL8",        3.75, 1, '{0,0,0}, '{5,0,0},   '{2,0,0}, 0, 0, 2);
    run_case("R2 R4 R6 late BL2",         6.25, 1, '{0,0,0}, '{77,0,0},  '{0,0,0}, 0, 0, 3);
    run_case("R4 code3 BL8",              5.0,  1, '{0,0,0}, '{14,0,0},  '{3,0,0}, 0, 0, 4);
    run_case("R8 chained BL4",            5.0,  2, '{0,2,0}, '{0,20,0},  '{1,1,0}, 0, 0, 5);
    run_case("R9 early write cuts BL8",   3.75, 2, '{0,1,0}, '{8,4,0},   '{2,1,0}, 0, 0, 6);
    run_case("R9 R8 three writes",        5.0,  3, '{0,4,2}, '{8,3,5},   '{2,2,1}, 0, 0, 7);
    run_case("R10 cut after 2 pairs",     6.25, 1, '{0,0,0}, '{16,0,0},  '{2,0,0}, 2, 4, 8);
    run_case("R10 cut after 1 pair",      3.75, 1, '{0,0,0}, '{30,0,0},  '{1,0,0}, 1, 6, 9);
    run_case("R7 edges after burst",      5.0,  1, '{0,0,0}, '{41,0,0},  '{1,0,0}, 0, 6, 10);
    stray(4);                                                                         // R7 after bursts

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule